// File: doc/BRIEF.md
# Dual-Mode Transmit Command Controller

This block sits between the host and the transmit path and decides which of two feeders may fill the transmit FIFO. The host sees a single two-bit field that it writes as a command and reads back as status: `00` means the channel is idle with the FIFO drained. Writing `01` while idle starts the local transmit DMA engine. Writing `10` while idle sends a packet the host has already pushed by hand.

In hand-fed mode the host pushes bytes through a write-only data port. The block forwards each byte to the FIFO and counts it, up to a parameterised packet limit of 1518 bytes by default. When the serializer or the DMA engine reports completion, the field returns to `00` and the completion status byte is latched. A completed hand-fed send also clears the byte counter.

The block keeps the two feeders apart. A DMA start is refused while hand-fed bytes are pending. Data-port writes are dropped while any transmission is in progress. Oversized packets are refused at send time. Sticky error flags record refused commands and dropped writes until reset.

Top module: `txcmd_ctrl`

## Requirements
- R1: After reset the command field reads `00`, the byte count is 0, and `tx_status`, `oversize`, `cmd_err` and `port_err` are all 0.
- R2: Writing `01` while the field reads `00` and the byte count is 0 pulses `dma_start` in the same cycle, and the field reads `01` from the next cycle.
- R3: Writing `10` while the field reads `00`, the byte count is non-zero and `oversize` is 0 pulses `mac_send` in the same cycle, and the field reads `10` from the next cycle.
- R4: A `tx_done` pulse while the field is `01` or `10` returns the field to `00` on the next cycle and latches `tx_status_in` into `tx_status`.
- R5: A data-port write while the field reads `00` and the count is below the limit is passed to the FIFO in the same cycle with the same byte, and the count is one higher on the next cycle.
- R6: A data-port write while the count equals the limit is not passed to the FIFO. It sets `oversize`, and the count stays at the limit.
- R7: Writing `10` while idle with a zero count or with `oversize` set produces no `mac_send`, leaves the field at `00`, and sets `cmd_err`.
- R8: Writing `01` while idle with a non-zero count produces no `dma_start`, leaves the field at `00`, keeps the count, and sets `cmd_err`.
- R9: A data-port write while the field is `01` or `10`, or in the cycle a DMA start is accepted, is not passed to the FIFO. It leaves the count unchanged and sets the sticky `port_err`.
- R10: Command writes while the field is `01` or `10` are ignored. The values `00` and `11` written while idle are ignored and set no error.
- R11: Completion of a `10` send clears the byte count and `oversize` to 0.
- R12: A `tx_done` pulse while the field reads `00` leaves `tx_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Host write strobe for the command field |
| cmd_wdata | input | 2 | Command value written by the host |
| cmd_state | output | 2 | Command/status field as read by the host |
| data_wr | input | 1 | Host write strobe for the data port |
| data_in | input | 8 | Byte written to the data port |
| fifo_wr_en | output | 1 | Write enable toward the transmit FIFO |
| fifo_wr_data | output | 8 | Byte toward the transmit FIFO |
| dma_start | output | 1 | One-cycle start pulse to the local DMA engine |
| mac_send | output | 1 | One-cycle pulse telling the serializer to send the FIFO packet |
| tx_done | input | 1 | Completion pulse from the transmit path |
| tx_status_in | input | 8 | Status byte valid with `tx_done` |
| tx_status | output | 8 | Latched status of the last completed transmission |
| byte_count | output | 11 | Bytes accepted in hand-fed mode since the last send |
| oversize | output | 1 | A byte arrived beyond the packet limit |
| cmd_err | output | 1 | Sticky: a send or DMA command was refused |
| port_err | output | 1 | Sticky: a data-port write was dropped |

## Verification
Hand-fed packets of lengths 1, 2, 7, 64 and exactly the limit are pushed and sent. These runs separate an off-by-one in the counter or the limit compare from a correct count, and show the counter clearing after each send. A push past the limit then shows that the extra bytes are blocked and the send is refused. Commands and data writes are also issued in every state: DMA starts with pending bytes, pushes and commands during both busy states, and stray completions while idle. These runs show whether the interlock keys on the current state, on the count, or on neither.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {
    TXC_IDLE  = 2'b00,
    TXC_DMA   = 2'b01,
    TXC_FSEND = 2'b10
  } txc_state_e;

  localparam logic [1:0] CMD_DMA   = 2'b01;
  localparam logic [1:0] CMD_FSEND = 2'b10;
endpackage

// File: rtl/txc_rst_sync.sv
module txc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/txc_cmd_fsm.sv
module txc_cmd_fsm
  import txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] cmd_wdata,
  input  logic       cnt_zero,
  input  logic       ovf,
  input  logic       tx_done,
  output txc_state_e state,
  output logic       dma_go,
  output logic       send_go,
  output logic       reject,
  output logic       done_any,
  output logic       done_fsend
);
  txc_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    dma_go   = 1'b0;
    send_go  = 1'b0;
    reject   = 1'b0;
    done_any = 1'b0;
    unique case (state_q)
      TXC_IDLE: begin
        if (cmd_wr) begin
          if (cmd_wdata == CMD_DMA) begin
            if (cnt_zero) begin
              dma_go  = 1'b1;
              state_d = TXC_DMA;
            end else begin
              reject = 1'b1;
            end
          end else if (cmd_wdata == CMD_FSEND) begin
            if (!cnt_zero && !ovf) begin
              send_go = 1'b1;
              state_d = TXC_FSEND;
            end else begin
              reject = 1'b1;
            end
          end
        end
      end
      TXC_DMA, TXC_FSEND: begin
        if (tx_done) begin
          done_any = 1'b1;
          state_d  = TXC_IDLE;
        end
      end
      default: state_d = TXC_IDLE;
    endcase
  end

  assign done_fsend = done_any && (state_q == TXC_FSEND);
  assign state      = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TXC_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/txc_byte_cnt.sv
module txc_byte_cnt #(
  parameter int MAX_BYTES = 1518,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             open_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             fifo_we,
  output logic             drop
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ovf_q, ovf_d, ovf_en;
  logic             at_max, accept, over;

  assign at_max  = (cnt_q == MAX_C);
  assign accept  = wr_req && open_i;
  assign fifo_we = accept && !at_max;
  assign over    = accept && at_max;
  assign drop    = wr_req && !open_i;

  always_comb begin
    cnt_en = clear_i || fifo_we;
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
    ovf_en = clear_i || over;
    ovf_d  = !clear_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (ovf_en) ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/txc_status.sv
module txc_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_any,
  input  logic [7:0] status_in,
  input  logic       reject,
  input  logic       drop,
  output logic [7:0] status,
  output logic       cmd_err,
  output logic       port_err
);
  logic [7:0] stat_q;
  logic       cerr_q, perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      cerr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      if (done_any) stat_q <= status_in;
      if (reject)   cerr_q <= 1'b1;
      if (drop)     perr_q <= 1'b1;
    end
  end

  assign status   = stat_q;
  assign cmd_err  = cerr_q;
  assign port_err = perr_q;
endmodule

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
  import txc_pkg::*;
#(
  parameter int MAX_BYTES = 1518,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_wdata,
  output logic [1:0]       cmd_state,
  input  logic             data_wr,
  input  logic [7:0]       data_in,
  output logic             fifo_wr_en,
  output logic [7:0]       fifo_wr_data,
  output logic             dma_start,
  output logic             mac_send,
  input  logic             tx_done,
  input  logic [7:0]       tx_status_in,
  output logic [7:0]       tx_status,
  output logic [CNT_W-1:0] byte_count,
  output logic             oversize,
  output logic             cmd_err,
  output logic             port_err
);
  logic       rst_s_n;
  txc_state_e state;
  logic       dma_go, send_go, reject, done_any, done_fsend;
  logic       open_w, drop_w, cnt_zero;

  txc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign cnt_zero = (byte_count == '0);

  txc_cmd_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .cnt_zero   (cnt_zero),
    .ovf        (oversize),
    .tx_done    (tx_done),
    .state      (state),
    .dma_go     (dma_go),
    .send_go    (send_go),
    .reject     (reject),
    .done_any   (done_any),
    .done_fsend (done_fsend)
  );

  assign open_w = (state == TXC_IDLE) && !dma_go;

  txc_byte_cnt #(.MAX_BYTES(MAX_BYTES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_req  (data_wr),
    .open_i  (open_w),
    .clear_i (done_fsend),
    .count   (byte_count),
    .ovf     (oversize),
    .fifo_we (fifo_wr_en),
    .drop    (drop_w)
  );

  txc_status u_stat (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .done_any  (done_any),
    .status_in (tx_status_in),
    .reject    (reject),
    .drop      (drop_w),
    .status    (tx_status),
    .cmd_err   (cmd_err),
    .port_err  (port_err)
  );

  assign cmd_state    = state;
  assign fifo_wr_data = data_in;
  assign dma_start    = dma_go;
  assign mac_send     = send_go;
endmodule

// File: rtl/txcmd_ctrl_chk.sv
module txcmd_ctrl_chk #(
  parameter int MAX_BYTES = 1518,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             cmd_wr,
  input logic [1:0]       cmd_wdata,
  input logic [1:0]       cmd_state,
  input logic             data_wr,
  input logic             fifo_wr_en,
  input logic             dma_start,
  input logic             mac_send,
  input logic             tx_done,
  input logic [7:0]       tx_status_in,
  input logic [7:0]       tx_status,
  input logic [CNT_W-1:0] byte_count,
  input logic             oversize,
  input logic             cmd_err,
  input logic             port_err
);
  a_r2_dma_enter: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_wr && cmd_state == 2'b00 && cmd_wdata == 2'b01 && byte_count == '0)
      |=> cmd_state == 2'b01);

  a_r3_send_enter: assert property (@(posedge clk) disable iff (!rst_s_n)
    mac_send |=> cmd_state == 2'b10);

  a_r4_finish: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_state != 2'b00 && tx_done)
      |=> (cmd_state == 2'b00 && tx_status == $past(tx_status_in)));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_s_n)
    fifo_wr_en |=> byte_count == $past(byte_count) + 1'b1);

  a_r6_cap: assert property (@(posedge clk) disable iff (!rst_s_n)
    oversize |-> byte_count == CNT_W'(MAX_BYTES));

  a_r7_refuse_send: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_wr && cmd_state == 2'b00 && cmd_wdata == 2'b10 && (oversize || byte_count == '0))
      |-> (!mac_send ##1 (cmd_err && cmd_state == 2'b00)));

  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_s_n)
    (data_wr && cmd_state != 2'b00) |-> (!fifo_wr_en ##1 port_err));

  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_state != 2'b00 && !tx_done) |=> $stable(cmd_state));

  a_r12_idle_status: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_state == 2'b00) |=> $stable(tx_status));

  a_r2_no_double: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(dma_start && mac_send));
endmodule

bind txcmd_ctrl txcmd_ctrl_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .cmd_wr       (cmd_wr),
  .cmd_wdata    (cmd_wdata),
  .cmd_state    (cmd_state),
  .data_wr      (data_wr),
  .fifo_wr_en   (fifo_wr_en),
  .dma_start    (dma_start),
  .mac_send     (mac_send),
  .tx_done      (tx_done),
  .tx_status_in (tx_status_in),
  .tx_status    (tx_status),
  .byte_count   (byte_count),
  .oversize     (oversize),
  .cmd_err      (cmd_err),
  .port_err     (port_err)
);

// File: tb/sim_txcmd_ctrl.sv
`timescale 1ns/1ps
module sim_txcmd_ctrl;
  localparam int LIM = 1518;
  localparam int CW  = $clog2(LIM + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_wr;
  logic [1:0]    cmd_wdata;
  logic [1:0]    cmd_state;
  logic          data_wr;
  logic [7:0]    data_in;
  logic          fifo_wr_en;
  logic [7:0]    fifo_wr_data;
  logic          dma_start, mac_send;
  logic          tx_done;
  logic [7:0]    tx_status_in, tx_status;
  logic [CW-1:0] byte_count;
  logic          oversize, cmd_err, port_err;

  int tests = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txcmd_ctrl #(.MAX_BYTES(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_state(cmd_state), .data_wr(data_wr), .data_in(data_in),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .dma_start(dma_start), .mac_send(mac_send), .tx_done(tx_done),
    .tx_status_in(tx_status_in), .tx_status(tx_status),
    .byte_count(byte_count), .oversize(oversize),
    .cmd_err(cmd_err), .port_err(port_err)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    exp_cnt = 0;
  endtask

  task automatic check_reset();
    chk("R1 field", 32'(cmd_state), 32'd0);
    chk("R1 count", 32'(byte_count), 32'd0);
    chk("R1 status", 32'(tx_status), 32'd0);
    chk("R1 flags", {29'd0, oversize, cmd_err, port_err}, 32'd0);
  endtask

  task automatic push_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      logic exp_we;
      data_wr = 1'b1;
      data_in = 8'(i * 7 + 3);
      exp_we  = (exp_cnt < LIM);
      #1;
      if (fifo_wr_en !== exp_we)
        chk(exp_we ? "R5 write forwarded" : "R6 write blocked", 32'(fifo_wr_en), 32'(exp_we));
      if (exp_we && fifo_wr_data !== data_in)
        chk("R5 byte passed", 32'(fifo_wr_data), 32'(data_in));
      tick();
      if (exp_cnt < LIM) exp_cnt++;
    end
    data_wr = 1'b0;
    tests++;
  endtask

  task automatic command(input logic [1:0] v);
    cmd_wr = 1'b1;
    cmd_wdata = v;
    #1;
  endtask

  task automatic finish_tx(input logic [7:0] st);
    tx_done = 1'b1;
    tx_status_in = st;
    tick();
    tx_done = 1'b0;
    tx_status_in = 8'h00;
  endtask

  task automatic fifo_packet(input int sz);
    logic [7:0] st;
    st = 8'(sz) ^ 8'hA5;
    push_bytes(sz);
    chk($sformatf("R5 count after %0d bytes", sz), 32'(byte_count), 32'(sz));
    command(2'b10);
    chk("R3 send pulse", 32'(mac_send), 32'd1);
    chk("R3 no dma pulse", 32'(dma_start), 32'd0);
    tick();
    cmd_wr = 1'b0;
    chk("R3 field 10", 32'(cmd_state), 32'd2);
    // R9 push while sending
    data_wr = 1'b1;
    data_in = 8'hEE;
    #1;
    chk("R9 busy push blocked", 32'(fifo_wr_en), 32'd0);
    tick();
    data_wr = 1'b0;
    chk("R9 port_err set", 32'(port_err), 32'd1);
    chk("R9 count kept", 32'(byte_count), 32'(sz));
    // R10 command while busy
    command(2'b01);
    chk("R10 busy dma refused", 32'(dma_start), 32'd0);
    tick();
    cmd_wr = 1'b0;
    chk("R10 field held", 32'(cmd_state), 32'd2);
    finish_tx(st);
    chk("R4 field idle", 32'(cmd_state), 32'd0);
    chk("R4 status latched", 32'(tx_status), 32'(st));
    chk("R11 count cleared", 32'(byte_count), 32'd0);
    exp_cnt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cmd_wr = 1'b0; cmd_wdata = 2'b00; data_wr = 1'b0; data_in = 8'h00;
    tx_done = 1'b0; tx_status_in = 8'h00;
    @(negedge clk);
    do_reset();
    check_reset();

    // R10 idle values 00 and 11
    command(2'b11);
    chk("R10 11 no dma", 32'(dma_start), 32'd0);
    chk("R10 11 no send", 32'(mac_send), 32'd0);
    tick();
    command(2'b00);
    tick();
    cmd_wr = 1'b0;
    chk("R10 field idle", 32'(cmd_state), 32'd0);
    chk("R10 no error", 32'(cmd_err), 32'd0);

    // R12 stray completion
    finish_tx(8'h77);
    chk("R12 status unchanged", 32'(tx_status), 32'd0);

    // R2 DMA start and finish
    command(2'b01);
    chk("R2 dma pulse", 32'(dma_start), 32'd1);
    data_wr = 1'b1; data_in = 8'h11;
    #1;
    chk("R9 push with dma start blocked", 32'(fifo_wr_en), 32'd0);
    tick();
    cmd_wr = 1'b0; data_wr = 1'b0;
    chk("R2 field 01", 32'(cmd_state), 32'd1);
    chk("R9 port_err sticky", 32'(port_err), 32'd1);
    chk("R9 count zero", 32'(byte_count), 32'd0);
    finish_tx(8'h3C);
    chk("R4 dma done field", 32'(cmd_state), 32'd0);
    chk("R4 dma status", 32'(tx_status), 32'h3C);

    // R7 send with empty count
    command(2'b10);
    chk("R7 empty no send", 32'(mac_send), 32'd0);
    tick();
    cmd_wr = 1'b0;
    chk("R7 field idle", 32'(cmd_state), 32'd0);
    chk("R7 cmd_err", 32'(cmd_err), 32'd1);

    // R8 dma with pending bytes
    push_bytes(3);
    command(2'b01);
    chk("R8 no dma", 32'(dma_start), 32'd0);
    tick();
    cmd_wr = 1'b0;
    chk("R8 field idle", 32'(cmd_state), 32'd0);
    chk("R8 count kept", 32'(byte_count), 32'd3);
    command(2'b10);
    tick();
    cmd_wr = 1'b0;
    finish_tx(8'h01);
    exp_cnt = 0;

    // R5 R11 sweep of packet lengths
    fifo_packet(1);
    fifo_packet(2);
    fifo_packet(7);
    fifo_packet(64);
    fifo_packet(LIM);

    // R6 past the limit, then R7 refusal
    push_bytes(LIM + 2);
    chk("R6 count capped", 32'(byte_count), 32'(LIM));
    chk("R6 oversize", 32'(oversize), 32'd1);
    command(2'b10);
    chk("R7 oversize no send", 32'(mac_send), 32'd0);
    tick();
    cmd_wr = 1'b0;
    chk("R7 oversize field idle", 32'(cmd_state), 32'd0);

    do_reset();
    check_reset();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule